// File: doc/BRIEF.md
# Vectored Single-Level Interrupt Sequencer

This block is the interrupt control logic of a small multi-cycle 16-bit processor. It watches the instruction word that the core presents at decode for two dedicated instructions. One loads the interrupt vector (the service routine address) from a general register. The other returns from the service routine. The block holds the vector register, the saved return address, an in-service bit and a sticky pending flag. The pending flag is set by each rising edge of the video vertical sync signal.

After each instruction's execute phase the core spends one cycle in a check step, marked by `chk_req`. In the following cycle the block answers with `chk_done`. If it wants the core to jump, it raises `redirect` and drives `redirect_pc` in that same cycle. A return instruction always redirects to the saved address. An interrupt is taken only when three things hold: the vector is nonzero, no routine is in service and an event is pending. A zero vector therefore disables interrupts, and there is no nesting.

Top module: `irq_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `chk_done`, `redirect` and `in_service` are 0. The vector register, return register and pending flag are also cleared: an event alone cannot cause a redirect until a nonzero vector has been loaded.
- R2: The vector-load instruction has bits 15:11 = 01111, bits 10:8 = register number and bits 7:0 = 0. When it is presented with `dec_valid` high, it loads the vector from `src_data`. `src_sel` shows bits 10:8 of `dec_instr` combinationally, so the core can supply that register's value.
- R3: `chk_done` is 1 in exactly the cycle after each cycle in which `chk_req` is 1, and 0 otherwise.
- R4: An interrupt is taken at a check when four things hold: no return is waiting, the vector is nonzero, `in_service` is 0 and an event is pending. In the `chk_done` cycle `redirect` is 1 and `redirect_pc` equals the vector. `resume_pc` is saved as the return address, `in_service` becomes 1 and the pending flag clears.
- R5: While the vector is 0, a check never redirects for an event. The pending flag stays set and is taken at the first check after a nonzero vector is loaded.
- R6: The return instruction is exactly 0x7000. Once it has been decoded, the next check gives `redirect` = 1 with `redirect_pc` equal to the saved return address, and clears `in_service`. No interrupt is taken at that same check.
- R7: A rising edge of `vsync` sets the sticky pending flag. Any number of edges before a take yield one interrupt, and after the take no further interrupt occurs until a new edge.
- R8: An edge that arrives while `in_service` is 1 stays pending. It causes no redirect while in service, and it is taken at the first check after the return's check.
- R9: Any word that does not exactly match either encoding has no effect on the vector, the return address or `in_service`. Examples are 0x7001, and 0x7D01 (the load pattern with a nonzero low byte).
- R10: `redirect` is 1 only in a `chk_done` cycle. A check with no return waiting and no takeable event gives `redirect` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Vertical sync level from the video output |
| dec_valid | input | 1 | `dec_instr` holds the instruction in decode this cycle |
| dec_instr | input | 16 | Instruction word |
| src_sel | output | 3 | Register number field of the decoded word |
| src_data | input | 16 | Value of the register chosen by `src_sel` |
| chk_req | input | 1 | Core is in its one-cycle check step |
| resume_pc | input | 16 | Address of the next instruction to execute |
| chk_done | output | 1 | Check answer valid (one cycle after `chk_req`) |
| redirect | output | 1 | Core must load `redirect_pc` into its PC |
| redirect_pc | output | 16 | Jump target: the vector or the saved return address |
| in_service | output | 1 | A service routine is running |

## Verification
Decode takes effect at the clock edge that samples `dec_valid`. A `vsync` rise becomes pending at the edge that first sees it high. The check answer (`chk_done`, `redirect`, `redirect_pc` and the new `in_service`) appears after the edge that samples `chk_req`. The bench drives every input on the falling edge and holds it through exactly one rising edge. It reads the answer just after that rising edge and compares it with a model updated in the same order. `src_sel` is combinational, so it is read after a settling delay in the same cycle it is driven.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   localparam int unsigned OPC_W = 5;
   localparam logic [OPC_W-1:0] SETVEC_OPC = 5'b01111;
   localparam logic [OPC_W-1:0] RETI_OPC   = 5'b01110;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_SETVEC = 2'd1,
      OP_RETI   = 2'd2
   } irq_op_e;

   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_TAKE = 2'd1,
      ACT_RET  = 2'd2
   } chk_act_e;
endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
   import irq_seq_pkg::*;
#(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned SEL_W   = 3
) (
   input  logic               valid,
   input  logic [INSTR_W-1:0] instr,
   output logic [SEL_W-1:0]   sel,
   output irq_op_e            op
);
   localparam int unsigned LOW_W = INSTR_W - OPC_W - SEL_W;

   if (LOW_W < 1) begin : g_bad_fields
      $error("irq_op_decode: INSTR_W too small for opcode and select fields");
   end

   logic [OPC_W-1:0] opc;
   logic [LOW_W-1:0] low;

   assign opc = instr[INSTR_W-1 -: OPC_W];
   assign sel = instr[INSTR_W-OPC_W-1 -: SEL_W];
   assign low = instr[LOW_W-1:0];

   always_comb begin
      op = OP_NONE;
      if (valid && low == '0) begin
         if (opc == SETVEC_OPC)
            op = OP_SETVEC;
         else if (opc == RETI_OPC && sel == '0)
            op = OP_RETI;
      end
   end
endmodule

// File: rtl/irq_vsync_event.sv
module irq_vsync_event #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   input  logic take,
   output logic pending
);
   logic vs_s;
   logic vs_q;

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("irq_vsync_event: SYNC_STAGES above 4 is not supported");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign vs_s = vsync;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], vsync};
      end
      assign vs_s = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q    <= 1'b0;
         pending <= 1'b0;
      end else begin
         vs_q <= vs_s;
         if (vs_s && !vs_q)
            pending <= 1'b1;
         else if (take)
            pending <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_chk_arbiter.sv
module irq_chk_arbiter
   import irq_seq_pkg::*;
(
   input  logic     chk_req,
   input  logic     reti_wait,
   input  logic     vec_nz,
   input  logic     busy,
   input  logic     pending,
   output chk_act_e act
);
   always_comb begin
      act = ACT_IDLE;
      if (chk_req) begin
         if (reti_wait)
            act = ACT_RET;
         else if (vec_nz && !busy && pending)
            act = ACT_TAKE;
      end
   end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
   import irq_seq_pkg::*;
#(
   parameter int unsigned PC_W        = 16,
   parameter int unsigned INSTR_W     = 16,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vsync,
   input  logic               dec_valid,
   input  logic [INSTR_W-1:0] dec_instr,
   output logic [SEL_W-1:0]   src_sel,
   input  logic [PC_W-1:0]    src_data,
   input  logic               chk_req,
   input  logic [PC_W-1:0]    resume_pc,
   output logic               chk_done,
   output logic               redirect,
   output logic [PC_W-1:0]    redirect_pc,
   output logic               in_service
);
   if (PC_W < 2) begin : g_bad_pc
      $error("irq_sequencer: PC_W must be at least 2");
   end
   if (SEL_W < 1) begin : g_bad_sel
      $error("irq_sequencer: SEL_W must be at least 1");
   end

   irq_op_e   op;
   chk_act_e  act;
   logic      pending;
   logic      reti_wait;
   logic [PC_W-1:0] isr_q;
   logic [PC_W-1:0] ret_q;

   irq_op_decode #(
      .INSTR_W (INSTR_W),
      .SEL_W   (SEL_W)
   ) u_dec (
      .valid (dec_valid),
      .instr (dec_instr),
      .sel   (src_sel),
      .op    (op)
   );

   irq_vsync_event #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .vsync   (vsync),
      .take    (act == ACT_TAKE),
      .pending (pending)
   );

   irq_chk_arbiter u_arb (
      .chk_req   (chk_req),
      .reti_wait (reti_wait),
      .vec_nz    (isr_q != '0),
      .busy      (in_service),
      .pending   (pending),
      .act       (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q     <= '0;
         reti_wait <= 1'b0;
      end else begin
         if (op == OP_SETVEC)
            isr_q <= src_data;
         if (op == OP_RETI)
            reti_wait <= 1'b1;
         else if (act == ACT_RET)
            reti_wait <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_q       <= '0;
         in_service  <= 1'b0;
         chk_done    <= 1'b0;
         redirect    <= 1'b0;
         redirect_pc <= '0;
      end else begin
         chk_done <= chk_req;
         redirect <= 1'b0;
         unique case (act)
            ACT_TAKE: begin
               redirect    <= 1'b1;
               redirect_pc <= isr_q;
               ret_q       <= resume_pc;
               in_service  <= 1'b1;
            end
            ACT_RET: begin
               redirect    <= 1'b1;
               redirect_pc <= ret_q;
               in_service  <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
   parameter int unsigned PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dec_valid,
   input logic            chk_req,
   input logic            chk_done,
   input logic            redirect,
   input logic            in_service,
   input logic            reti_wait,
   input logic [PC_W-1:0] isr
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!chk_done && !redirect && !in_service));

   // R3
   done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req |=> chk_done);

   // R3
   no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_req |=> !chk_done);

   // R10
   redirect_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> chk_done);

   // R4
   service_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_service) |-> redirect);

   // R6
   service_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_service) |-> redirect);

   // R2
   vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> $stable(isr));

   // R8
   no_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && in_service && !reti_wait) |=> !redirect);
endmodule

bind irq_sequencer irq_sequencer_chk #(.PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_valid  (dec_valid),
   .chk_req    (chk_req),
   .chk_done   (chk_done),
   .redirect   (redirect),
   .in_service (in_service),
   .reti_wait  (reti_wait),
   .isr        (isr_q)
);

// File: tb/irq_sequencer_test.sv
module irq_sequencer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vsync = 1'b0;
   logic        dec_valid = 1'b0;
   logic [15:0] dec_instr = 16'h0000;
   logic [2:0]  src_sel;
   logic [15:0] src_data = 16'h0000;
   logic        chk_req = 1'b0;
   logic [15:0] resume_pc = 16'h0000;
   logic        chk_done;
   logic        redirect;
   logic [15:0] redirect_pc;
   logic        in_service;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [15:0] m_isr = 16'h0;
   logic [15:0] m_ret = 16'h0;
   logic        m_svc = 1'b0;
   logic        m_pend = 1'b0;
   logic        m_rti = 1'b0;

   irq_sequencer uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .vsync       (vsync),
      .dec_valid   (dec_valid),
      .dec_instr   (dec_instr),
      .src_sel     (src_sel),
      .src_data    (src_data),
      .chk_req     (chk_req),
      .resume_pc   (resume_pc),
      .chk_done    (chk_done),
      .redirect    (redirect),
      .redirect_pc (redirect_pc),
      .in_service  (in_service)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit is_setvec(input logic [15:0] w);
      return w[15:11] == 5'b01111 && w[7:0] == 8'h00;
   endfunction

   function automatic bit is_reti(input logic [15:0] w);
      return w == 16'h7000;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_decode(input logic [15:0] w, input logic [15:0] data);
      @(negedge clk);
      dec_valid = 1'b1;
      dec_instr = w;
      src_data  = data;
      @(negedge clk);
      dec_valid = 1'b0;
      if (is_setvec(w)) m_isr = data;
      if (is_reti(w))   m_rti = 1'b1;
   endtask

   task automatic vs_pulse();
      @(negedge clk);
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
      m_pend = 1'b1;
   endtask

   task automatic do_check(input logic [15:0] pc, input string req);
      logic        e_red;
      logic [15:0] e_pc;
      e_red = 1'b0;
      e_pc  = 16'h0;
      if (m_rti) begin
         e_red = 1'b1; e_pc = m_ret; m_svc = 1'b0; m_rti = 1'b0;
      end else if (m_isr != 16'h0 && !m_svc && m_pend) begin
         e_red = 1'b1; e_pc = m_isr; m_ret = pc; m_svc = 1'b1; m_pend = 1'b0;
      end
      @(negedge clk);
      chk_req   = 1'b1;
      resume_pc = pc;
      @(posedge clk);
      #1;
      check("R3", "chk_done", 32'(chk_done), 32'd1);
      check(req, "redirect", 32'(redirect), 32'(e_red));
      if (e_red) check(req, "redirect_pc", 32'(redirect_pc), 32'(e_pc));
      check(req, "in_service", 32'(in_service), 32'(m_svc));
      @(negedge clk);
      chk_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      check("R1", "chk_done in reset", 32'(chk_done), 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", "chk_done", 32'(chk_done), 32'd0);
      check("R1", "redirect", 32'(redirect), 32'd0);
      check("R1", "in_service", 32'(in_service), 32'd0);

      // R5: event with zero vector is not taken
      vs_pulse();
      do_check(16'h0100, "R5");

      // R2: select field shown combinationally
      @(negedge clk);
      dec_instr = 16'h7D00;
      #1;
      check("R2", "src_sel", 32'(src_sel), 32'd5);
      do_decode(16'h7D00, 16'h1234);
      // R5: held event taken once vector is nonzero
      do_check(16'h0101, "R5");

      // R8: edge during service held
      vs_pulse();
      do_check(16'h1235, "R8");
      // R9: near-miss encodings ignored
      do_decode(16'h7001, 16'h0000);
      do_check(16'h1236, "R9");
      do_decode(16'h7D01, 16'h0000);
      do_check(16'h1237, "R9");
      // R6: return
      do_decode(16'h7000, 16'h0000);
      do_check(16'h1238, "R6");
      // R8: held event taken after return (vector untouched, R9)
      do_check(16'h0102, "R8");
      do_decode(16'h7000, 16'h0000);
      do_check(16'h1239, "R6");
      // R10: idle check
      do_check(16'h0103, "R10");

      // R7: several edges give one interrupt
      vs_pulse(); vs_pulse(); vs_pulse();
      do_check(16'h0104, "R7");
      do_decode(16'h7000, 16'h0000);
      do_check(16'h123A, "R6");
      do_check(16'h0105, "R7");

      // R5: zero vector disables, then re-enable
      do_decode(16'h7A00, 16'h0000);
      vs_pulse();
      do_check(16'h0106, "R5");
      do_decode(16'h7B00, 16'h0800);
      do_check(16'h0107, "R5");
      do_decode(16'h7000, 16'h0000);
      do_check(16'h0801, "R6");

      // R4: constrained random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned kind;
         logic [15:0] w;
         kind = $urandom_range(0, 5);
         case (kind)
            0: begin
               w = {5'b01111, 3'($urandom_range(0, 7)), 8'h00};
               do_decode(w, ($urandom_range(0, 3) == 0) ? 16'h0000
                                                       : 16'($urandom));
            end
            1: do_decode(16'h7000, 16'h0000);
            2: begin
               w = 16'($urandom);
               if (is_setvec(w) || is_reti(w)) w[0] = 1'b1;
               do_decode(w, 16'($urandom));
            end
            3: vs_pulse();
            default: ;
         endcase
         do_check(16'($urandom), "R4");
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule